// File: doc/BRIEF.md
# Multi-CPU indexed interrupt controller

This block gathers level-sensitive interrupt lines and delivers them to a small set of CPUs. Software configures it through two register ports. The global port holds the controller-wide switch, the enable state of each shared source and one routing word per source. The per-CPU port is banked: a CPU-select input chooses which CPU's copy is accessed. It holds that CPU's private-source masks, its threshold, a bitmap of its pending private lines, and an acknowledge register.

Sources below `NPRIV` are private. Every CPU has its own set of lines for these numbers. Each CPU unmasks them for itself through its banked window, and they do not use the routing words. Sources from `NPRIV` up to `NSRC-1` are shared. Writing the source number to one global register enables a shared source, and writing it to another disables it. Its routing word picks which CPUs see it as a normal interrupt (IRQ) and which see it as a fast interrupt (FIQ).

For each CPU the acknowledge register reports the lowest-numbered source that may interrupt that CPU, and `irq_o` shows whether any such source exists. Reading the acknowledge register changes nothing. A source stays pending until its line drops. All reads return data in the same cycle, and writes take effect at the next clock edge.

Top module: `mcpu_irq_ctrl`

## Requirements
- R1: After reset the controller is off, all shared sources are disabled, all routing words are zero, all private sources are masked and every threshold is zero. The acknowledge register of each CPU reads 0x3FF, and `irq_o` and `fiq_o` are all zero.
- R2: Global offset 0x000 is the control register. Bit 0 is the controller-wide enable and reads back as written. Bits [11:2] read the value of `NSRC`. While bit 0 is 0, no IRQ or FIQ is asserted and every acknowledge register reads 0x3FF.
- R3: Writing n to global offset 0x030 enables shared source n, and writing n to global offset 0x034 disables it, for NPRIV <= n < NSRC (n taken from write-data bits [9:0]). Any other number written there changes nothing.
- R4: The routing word of source n is at global offset 0x100 + 4n. Bit c routes the source to CPU c as IRQ, and bit 8+c routes it to CPU c as FIQ. Only those bits are stored and read back. A shared source reaches a CPU's IRQ only if its IRQ routing bit for that CPU is set.
- R5: Private source n (n < NPRIV) of CPU c is unmasked by writing n to per-CPU offset 0x04C with `p_cpu` = c, and masked by writing n to per-CPU offset 0x048. The write affects only CPU c. Numbers of NPRIV or above written there change nothing. Private sources ignore routing words and shared enables.
- R6: Per-CPU offset 0x010 reads, in bit n, whether private line n of that CPU is high and unmasked.
- R7: Per-CPU offset 0x044 reads, in bits [9:0], the lowest-numbered source that is pending and eligible for that CPU, or 0x3FF if there is none. Bits above 9 read as zero.
- R8: `irq_o[c]` is high exactly when CPU c's acknowledge value is not 0x3FF.
- R9: Per-CPU offset 0x040 is an 8-bit threshold that reads back as written. While it is nonzero, that CPU's IRQ is held off and its acknowledge register reads 0x3FF. Other CPUs and FIQ are unaffected.
- R10: `fiq_o[c]` is high when the controller is on and any enabled shared source with its line high has its FIQ routing bit for CPU c set.
- R11: Reading the acknowledge register has no side effects. A source stays reported until its line drops or its enable or mask is removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| g_addr | input | 12 | Global window byte address |
| g_wr | input | 1 | Global write strobe |
| g_wdata | input | 32 | Global write data |
| g_rdata | output | 32 | Global read data (combinational) |
| p_cpu | input | CPUW | CPU whose banked window is accessed |
| p_addr | input | 12 | Per-CPU window byte address |
| p_wr | input | 1 | Per-CPU write strobe |
| p_wdata | input | 32 | Per-CPU write data |
| p_rdata | output | 32 | Per-CPU read data (combinational) |
| priv_in | input | NCPU*NPRIV | Private lines, CPU c at bits [c*NPRIV +: NPRIV] |
| shr_in | input | NSRC-NPRIV | Shared lines, bit i is source NPRIV+i |
| irq_o | output | NCPU | Per-CPU normal interrupt request |
| fiq_o | output | NCPU | Per-CPU fast interrupt request |

## Verification
On every cycle, the assertions check the following:
- The acknowledge value is always an eligible source, and no lower-numbered source is eligible.
- Index writes set and clear exactly the addressed enable or mask bit.
- A banked write leaves the masks of every other CPU alone.
- The controller switch and a nonzero threshold silence the outputs.
- The acknowledge value cannot move while the inputs and registers are quiet.

The bench scenarios are needed for the rest:
- that every source number in the small configuration reaches exactly the CPU it is routed to;
- that out-of-band index writes are ignored;
- that the pending bitmap is correct;
- how the lowest-number order unfolds as sources are removed one by one.

// File: rtl/irqc_pkg.sv
// Package: shared widths and register offsets of the multi-CPU interrupt
// controller. Assumes byte addresses with 32-bit registers.
package irqc_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 10;
    localparam int THR_W     = 8;
    localparam int FIQ_SHIFT = 8;

    localparam logic [IDX_W-1:0]  IDX_NONE = 10'h3FF;

    // global window
    localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SET_EN     = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_CLR_EN     = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 12'h100;

    // per-CPU window
    localparam logic [ADDR_W-1:0] OFS_PRIV_PEND  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_THRESH     = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_ACK        = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_PMASK      = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_PUNMASK    = 12'h04C;
endpackage

// File: rtl/irqc_global.sv
// Module: global register window. Holds the controller-wide enable, the
// enable bit of every shared source (set/clear by index) and the routing
// word of every source. Assumes NPRIV < NSRC <= 1023 and NCPU <= 8.
module irqc_global
    import irqc_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NSRC  = 128,
    parameter int NPRIV = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           g_addr,
    input  logic                        g_wr,
    input  logic [DATA_W-1:0]           g_wdata,
    output logic [DATA_W-1:0]           g_rdata,
    output logic                        ctl_en,
    output logic [NSRC-1:0]             src_en,
    output logic [NSRC-1:0][NCPU-1:0]   route_irq,
    output logic [NSRC-1:0][NCPU-1:0]   route_fiq
);
    localparam int NSHR    = NSRC - NPRIV;
    localparam int RT_SPAN = 4 * NSRC;

    logic                ctl_q;
    logic [NSHR-1:0]     en_shr_q;
    logic [IDX_W-1:0]    wr_idx;
    logic                idx_shared;
    logic                wr_set;
    logic                wr_clr;
    logic [ADDR_W-1:0]   rt_off;
    logic [IDX_W-1:0]    rt_idx;
    logic                rt_hit;

    // decode the written index and the routing-word address
    assign wr_idx     = g_wdata[IDX_W-1:0];
    assign idx_shared = (wr_idx >= IDX_W'(NPRIV)) && (wr_idx < IDX_W'(NSRC));
    assign wr_set     = g_wr && (g_addr == OFS_SET_EN) && idx_shared;
    assign wr_clr     = g_wr && (g_addr == OFS_CLR_EN) && idx_shared;
    assign rt_off     = g_addr - OFS_ROUTE_BASE;
    assign rt_idx     = rt_off[ADDR_W-1:2];
    assign rt_hit     = (g_addr >= OFS_ROUTE_BASE) && (rt_off < ADDR_W'(RT_SPAN))
                        && (g_addr[1:0] == 2'b00);

    // controller-wide enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= 1'b0;
        else if (g_wr && (g_addr == OFS_CTRL))
            ctl_q <= g_wdata[0];
    end

    // shared-source enables, set or cleared by writing the source number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_shr_q <= '0;
        end else begin
            for (int i = 0; i < NSHR; i++) begin
                if (wr_set && (wr_idx == IDX_W'(i + NPRIV)))
                    en_shr_q[i] <= 1'b1;
                else if (wr_clr && (wr_idx == IDX_W'(i + NPRIV)))
                    en_shr_q[i] <= 1'b0;
            end
        end
    end

    // per-source routing words (IRQ and FIQ target bits only)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_irq <= '0;
            route_fiq <= '0;
        end else if (g_wr && rt_hit) begin
            for (int n = 0; n < NSRC; n++) begin
                if (rt_idx == IDX_W'(n)) begin
                    route_irq[n] <= g_wdata[NCPU-1:0];
                    route_fiq[n] <= g_wdata[FIQ_SHIFT +: NCPU];
                end
            end
        end
    end

    // combinational read mux of the global window
    always_comb begin
        g_rdata = '0;
        if (g_addr == OFS_CTRL) begin
            g_rdata[0]         = ctl_q;
            g_rdata[IDX_W+1:2] = IDX_W'(NSRC);
        end
        for (int n = 0; n < NSRC; n++) begin
            if (rt_hit && (rt_idx == IDX_W'(n))) begin
                g_rdata[NCPU-1:0]         = route_irq[n];
                g_rdata[FIQ_SHIFT +: NCPU] = route_fiq[n];
            end
        end
    end

    assign ctl_en = ctl_q;
    assign src_en = {en_shr_q, {NPRIV{1'b0}}};

    logic unused_gbits;
    assign unused_gbits = ^{g_wdata, rt_off[1:0]};

    // R3: a set-enable write turns on exactly the addressed source
    p_set_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (((src_en >> $past(wr_idx)) & NSRC'(1)) != '0));

    // R3: a clear-enable write turns the addressed source off
    p_clr_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> (((src_en >> $past(wr_idx)) & NSRC'(1)) == '0));

    // R3: index writes outside the shared band leave every enable alone
    p_bad_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (g_wr && ((g_addr == OFS_SET_EN) || (g_addr == OFS_CLR_EN)) && !idx_shared)
        |=> $stable(src_en));

    // R2: the control bit follows the last write to the control register
    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (g_wr && (g_addr == OFS_CTRL)) |=> (ctl_en == $past(g_wdata[0])));
endmodule

// File: rtl/irqc_cpu_bank.sv
// Module: banked per-CPU registers. Holds each CPU's private-source unmask
// bits (set/clear by index) and its threshold. Assumes NPRIV <= 32 and that
// p_cpu selects the bank being written.
module irqc_cpu_bank
    import irqc_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NPRIV = 32,
    parameter int CPUW  = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CPUW-1:0]                p_cpu,
    input  logic [ADDR_W-1:0]              p_addr,
    input  logic                           p_wr,
    input  logic [DATA_W-1:0]              p_wdata,
    output logic [NCPU-1:0][NPRIV-1:0]     priv_unm,
    output logic [NCPU-1:0][THR_W-1:0]     thr
);
    logic [IDX_W-1:0] wr_idx;
    logic             idx_priv;
    logic             wr_unm;
    logic             wr_msk;
    logic             wr_thr;

    // decode the banked write
    assign wr_idx   = p_wdata[IDX_W-1:0];
    assign idx_priv = wr_idx < IDX_W'(NPRIV);
    assign wr_unm   = p_wr && (p_addr == OFS_PUNMASK) && idx_priv;
    assign wr_msk   = p_wr && (p_addr == OFS_PMASK) && idx_priv;
    assign wr_thr   = p_wr && (p_addr == OFS_THRESH);

    // per-CPU unmask bits and threshold, written only in the selected bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_unm <= '0;
            thr      <= '0;
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (p_cpu == CPUW'(c)) begin
                    if (wr_thr)
                        thr[c] <= p_wdata[THR_W-1:0];
                    for (int n = 0; n < NPRIV; n++) begin
                        if (wr_unm && (wr_idx == IDX_W'(n)))
                            priv_unm[c][n] <= 1'b1;
                        else if (wr_msk && (wr_idx == IDX_W'(n)))
                            priv_unm[c][n] <= 1'b0;
                    end
                end
            end
        end
    end

    logic unused_pbits;
    assign unused_pbits = ^p_wdata;

    for (genvar gc = 0; gc < NCPU; gc++) begin : g_chk
        // R5: an unmask write in this bank sets the addressed bit
        p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_unm && (p_cpu == CPUW'(gc)))
            |=> (((priv_unm[gc] >> $past(wr_idx)) & NPRIV'(1)) != '0));

        // R5: a mask write in this bank clears the addressed bit
        p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_msk && (p_cpu == CPUW'(gc)))
            |=> (((priv_unm[gc] >> $past(wr_idx)) & NPRIV'(1)) == '0));

        // R5: a write aimed at another CPU leaves this bank untouched
        p_other_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (p_cpu != CPUW'(gc)) |=> ($stable(priv_unm[gc]) && $stable(thr[gc])));
    end
endmodule

// File: rtl/irqc_pick.sv
// Module: lowest-number selector. Reports the lowest set bit of the eligible
// vector as a source number, or the "none" code when no bit is set.
// Assumes NSRC <= 1023 so the none code never collides with a source.
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int NSRC = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  elig,
    output logic [IDX_W-1:0] ack_idx,
    output logic             any
);
    // scan from the top so the lowest eligible number wins
    always_comb begin
        ack_idx = IDX_NONE;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (elig[n])
                ack_idx = IDX_W'(n);
        end
    end

    assign any = |elig;

    // R7: the reported source is itself eligible
    p_ack_elig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (((elig >> ack_idx) & NSRC'(1)) != '0));

    // R7: nothing below the reported source is eligible
    p_ack_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((elig & ~({NSRC{1'b1}} << ack_idx)) == '0));

    // R7: empty vector gives the none code
    p_ack_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (ack_idx == IDX_NONE));
endmodule

// File: rtl/mcpu_irq_ctrl.sv
// Module: top of the multi-CPU indexed interrupt controller. Forms each CPU's
// eligible vector from the private lines, shared lines, enables, routing and
// threshold, drives IRQ/FIQ and the banked read mux. Assumes level inputs
// already synchronous to clk.
module mcpu_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NSRC  = 128,
    parameter int NPRIV = 32,
    localparam int NSHR = NSRC - NPRIV,
    localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       g_addr,
    input  logic                    g_wr,
    input  logic [DATA_W-1:0]       g_wdata,
    output logic [DATA_W-1:0]       g_rdata,
    input  logic [CPUW-1:0]         p_cpu,
    input  logic [ADDR_W-1:0]       p_addr,
    input  logic                    p_wr,
    input  logic [DATA_W-1:0]       p_wdata,
    output logic [DATA_W-1:0]       p_rdata,
    input  logic [NCPU*NPRIV-1:0]   priv_in,
    input  logic [NSHR-1:0]         shr_in,
    output logic [NCPU-1:0]         irq_o,
    output logic [NCPU-1:0]         fiq_o
);
    logic                         ctl_en;
    logic [NSRC-1:0]              src_en;
    logic [NSRC-1:0][NCPU-1:0]    route_irq;
    logic [NSRC-1:0][NCPU-1:0]    route_fiq;
    logic [NCPU-1:0][NPRIV-1:0]   priv_unm;
    logic [NCPU-1:0][THR_W-1:0]   thr;
    logic [NCPU-1:0][IDX_W-1:0]   ack_all;
    logic [NCPU-1:0][NPRIV-1:0]   ppend;

    irqc_global #(.NCPU(NCPU), .NSRC(NSRC), .NPRIV(NPRIV)) u_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .g_addr    (g_addr),
        .g_wr      (g_wr),
        .g_wdata   (g_wdata),
        .g_rdata   (g_rdata),
        .ctl_en    (ctl_en),
        .src_en    (src_en),
        .route_irq (route_irq),
        .route_fiq (route_fiq)
    );

    irqc_cpu_bank #(.NCPU(NCPU), .NPRIV(NPRIV), .CPUW(CPUW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .p_cpu    (p_cpu),
        .p_addr   (p_addr),
        .p_wr     (p_wr),
        .p_wdata  (p_wdata),
        .priv_unm (priv_unm),
        .thr      (thr)
    );

    for (genvar gc = 0; gc < NCPU; gc++) begin : g_cpu
        logic [NSRC-1:0] raw;
        logic [NSRC-1:0] elig;
        logic            fiq_any;
        logic            any;

        // pending vector of this CPU before the controller and threshold gates
        always_comb begin
            for (int n = 0; n < NPRIV; n++)
                raw[n] = priv_in[gc*NPRIV + n] & priv_unm[gc][n];
            for (int n = NPRIV; n < NSRC; n++)
                raw[n] = shr_in[n - NPRIV] & src_en[n] & route_irq[n][gc];
        end

        // FIQ request from enabled shared sources routed as fast to this CPU
        always_comb begin
            fiq_any = 1'b0;
            for (int n = NPRIV; n < NSRC; n++)
                fiq_any = fiq_any | (shr_in[n - NPRIV] & src_en[n] & route_fiq[n][gc]);
        end

        assign elig = (ctl_en && (thr[gc] == '0)) ? raw : '0;

        irqc_pick #(.NSRC(NSRC)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .elig    (elig),
            .ack_idx (ack_all[gc]),
            .any     (any)
        );

        assign irq_o[gc] = any;
        assign fiq_o[gc] = ctl_en & fiq_any;
        assign ppend[gc] = priv_in[gc*NPRIV +: NPRIV] & priv_unm[gc];

        // R9: a nonzero threshold keeps this CPU's IRQ low
        p_thr_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (thr[gc] != '0) |-> (!irq_o[gc] && (ack_all[gc] == IDX_NONE)));

        // R8: IRQ line agrees with the acknowledge value
        p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[gc] == (ack_all[gc] != IDX_NONE));
    end

    // banked read mux of the per-CPU window
    always_comb begin
        p_rdata = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (p_cpu == CPUW'(c)) begin
                if (p_addr == OFS_PRIV_PEND) p_rdata[NPRIV-1:0] = ppend[c];
                if (p_addr == OFS_THRESH)    p_rdata[THR_W-1:0] = thr[c];
                if (p_addr == OFS_ACK)       p_rdata[IDX_W-1:0] = ack_all[c];
            end
        end
    end

    logic unused_top;
    assign unused_top = ^{route_irq[NPRIV-1:0], route_fiq[NPRIV-1:0], src_en[NPRIV-1:0]};

    // R2: with the controller switched off no request leaves the block
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> ((irq_o == '0) && (fiq_o == '0)));

    // R11: with no writes and steady lines the acknowledge values hold
    p_ack_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!g_wr && !p_wr) && $stable(shr_in) && $stable(priv_in))
        |-> $stable(ack_all));
endmodule

// File: tb/mcpu_irq_ctrl_bench.sv
module mcpu_irq_ctrl_bench;
    localparam int NCPU  = 2;
    localparam int NSRC  = 64;
    localparam int NPRIV = 32;
    localparam int NSHR  = NSRC - NPRIV;
    localparam logic [31:0] NONE = 32'h3FF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       g_addr = '0;
    logic              g_wr = 1'b0;
    logic [31:0]       g_wdata = '0;
    logic [31:0]       g_rdata;
    logic [0:0]        p_cpu = '0;
    logic [11:0]       p_addr = '0;
    logic              p_wr = 1'b0;
    logic [31:0]       p_wdata = '0;
    logic [31:0]       p_rdata;
    logic [NCPU*NPRIV-1:0] priv_in = '0;
    logic [NSHR-1:0]   shr_in = '0;
    logic [NCPU-1:0]   irq_o;
    logic [NCPU-1:0]   fiq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcpu_irq_ctrl #(.NCPU(NCPU), .NSRC(NSRC), .NPRIV(NPRIV)) u_mcpu_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .g_addr(g_addr), .g_wr(g_wr), .g_wdata(g_wdata), .g_rdata(g_rdata),
        .p_cpu(p_cpu), .p_addr(p_addr), .p_wr(p_wr), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .priv_in(priv_in), .shr_in(shr_in), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic gw(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        g_addr = a; g_wdata = d; g_wr = 1'b1;
        @(negedge clk);
        g_wr = 1'b0;
    endtask

    task automatic pw(input int c, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        p_cpu = 1'(c); p_addr = a; p_wdata = d; p_wr = 1'b1;
        @(negedge clk);
        p_wr = 1'b0;
    endtask

    task automatic grd(input logic [11:0] a, output logic [31:0] d);
        g_addr = a; #1; d = g_rdata;
    endtask

    task automatic prd(input int c, input logic [11:0] a, output logic [31:0] d);
        p_cpu = 1'(c); p_addr = a; #1; d = p_rdata;
    endtask

    task automatic chk_ack(input string tag, input int c, input logic [31:0] exp);
        logic [31:0] v;
        prd(c, 12'h044, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1..R11 got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 reset state and source count field
        grd(12'h000, v);         chk("R1 R2 ctrl reset", v, 32'(NSRC) << 2);
        chk_ack("R1 ack cpu0 reset", 0, NONE);
        chk_ack("R1 ack cpu1 reset", 1, NONE);
        chk("R1 irq reset", 32'(irq_o), 0);
        chk("R1 fiq reset", 32'(fiq_o), 0);

        // R2 controller off blocks a fully configured source
        gw(12'h100 + 12'(4*40), 32'h1);
        gw(12'h030, 40);
        shr_in[40-NPRIV] = 1'b1;
        #1 chk("R2 off no irq", 32'(irq_o), 0);
        chk_ack("R2 off ack", 0, NONE);
        gw(12'h000, 1);
        chk("R2 on irq", 32'(irq_o), 32'h1);
        grd(12'h000, v);         chk("R2 ctrl readback", v, (32'(NSRC) << 2) | 1);
        gw(12'h034, 40);
        shr_in = '0;
        gw(12'h100 + 12'(4*40), 0);

        // R3 R4 R7 R8 sweep every shared source to each CPU
        for (int n = NPRIV; n < NSRC; n++) begin
            for (int c = 0; c < NCPU; c++) begin
                gw(12'h100 + 12'(4*n), 32'(1 << c));
                gw(12'h030, 32'(n));
                shr_in[n-NPRIV] = 1'b1;
                chk_ack("R7 shared ack routed", c, 32'(n));
                chk_ack("R4 shared ack other cpu", 1 - c, NONE);
                chk("R8 irq routed", 32'(irq_o), 32'(1 << c));
                grd(12'h100 + 12'(4*n), v);
                chk("R4 route readback", v, 32'(1 << c));
                gw(12'h034, 32'(n));
                chk_ack("R3 clear enable", c, NONE);
                shr_in[n-NPRIV] = 1'b0;
                gw(12'h100 + 12'(4*n), 0);
            end
        end

        // R5 R6 sweep every private source on each CPU
        for (int c = 0; c < NCPU; c++) begin
            for (int n = 0; n < NPRIV; n++) begin
                priv_in[c*NPRIV + n] = 1'b1;
                chk_ack("R5 masked private", c, NONE);
                pw(c, 12'h04C, 32'(n));
                chk_ack("R5 unmasked private", c, 32'(n));
                chk_ack("R5 other cpu unaffected", 1 - c, NONE);
                prd(c, 12'h010, v);  chk("R6 pending bitmap", v, 32'(1) << n);
                pw(c, 12'h048, 32'(n));
                chk_ack("R5 remasked private", c, NONE);
                prd(c, 12'h010, v);  chk("R6 bitmap masked", v, 0);
                priv_in[c*NPRIV + n] = 1'b0;
            end
        end

        // R3 R5 ignored indices
        gw(12'h100 + 12'(4*40), 32'h3);
        shr_in[40-NPRIV] = 1'b1;
        priv_in[5] = 1'b1;
        priv_in[NPRIV + 5] = 1'b1;
        gw(12'h030, 5);
        gw(12'h030, 32'(NSRC));
        pw(0, 12'h04C, 40);
        chk_ack("R3 private idx not enabled", 0, NONE);
        chk_ack("R3 out-of-range idx ignored", 1, NONE);
        gw(12'h030, 40);
        chk_ack("R3 shared enable cpu0", 0, 40);
        chk_ack("R3 shared enable cpu1", 1, 40);
        pw(0, 12'h04C, 5);
        chk_ack("R7 private beats shared", 0, 5);
        chk_ack("R5 per-cpu unmask only", 1, 40);
        prd(1, 12'h010, v);     chk("R6 cpu1 bitmap still masked", v, 0);
        pw(0, 12'h04C, 45);
        chk_ack("R5 high idx unmask ignored", 0, 5);

        // R9 threshold
        pw(1, 12'h040, 3);
        chk_ack("R9 threshold blocks", 1, NONE);
        chk("R9 irq cpu1 low", 32'(irq_o), 32'h1);
        prd(1, 12'h040, v);     chk("R9 threshold readback", v, 3);
        chk_ack("R9 other cpu open", 0, 5);
        pw(1, 12'h040, 0);
        chk_ack("R9 threshold zero", 1, 40);
        pw(0, 12'h048, 5);
        chk_ack("R5 mask restores shared", 0, 40);
        gw(12'h034, 40);
        shr_in = '0; priv_in = '0;
        gw(12'h100 + 12'(4*40), 0);

        // R10 fast interrupt routing
        gw(12'h100 + 12'(4*50), 32'h100);
        gw(12'h030, 50);
        shr_in[50-NPRIV] = 1'b1;
        #1 chk("R10 fiq cpu0", 32'(fiq_o), 32'h1);
        chk("R10 no irq", 32'(irq_o), 0);
        chk_ack("R10 fiq-only ack", 0, NONE);
        pw(0, 12'h040, 1);
        chk("R9 R10 threshold leaves fiq", 32'(fiq_o), 32'h1);
        pw(0, 12'h040, 0);
        gw(12'h000, 0);
        chk("R2 R10 off no fiq", 32'(fiq_o), 0);
        gw(12'h000, 1);
        chk("R10 fiq back", 32'(fiq_o), 32'h1);
        gw(12'h100 + 12'(4*50), 32'hFFFF_FFFF);
        grd(12'h100 + 12'(4*50), v);
        chk("R4 route keeps only target bits", v, 32'h303);
        gw(12'h034, 50);
        chk("R10 disabled no fiq", 32'(fiq_o), 0);
        shr_in = '0;

        // R7 R11 lowest-number order, removing sources one at a time
        for (int n = NPRIV; n < NSRC; n++) begin
            gw(12'h100 + 12'(4*n), 32'h3);
            gw(12'h030, 32'(n));
        end
        shr_in = '1;
        for (int k = NPRIV; k < NSRC; k++) begin
            chk_ack("R7 lowest cpu0", 0, 32'(k));
            chk_ack("R11 ack reread", 0, 32'(k));
            chk_ack("R7 lowest cpu1", 1, 32'(k));
            if (k == 40) begin
                gw(12'h000, 0);
                chk("R2 off mid-sweep", 32'(irq_o), 0);
                chk_ack("R2 off mid-sweep ack", 1, NONE);
                gw(12'h000, 1);
            end
            gw(12'h034, 32'(k));
        end
        chk_ack("R7 all removed", 0, NONE);
        chk("R8 all removed irq", 32'(irq_o), 0);

        // R11 level hold and drop
        gw(12'h030, 45);
        repeat (3) @(negedge clk);
        chk_ack("R11 stays pending", 1, 45);
        shr_in[45-NPRIV] = 1'b0;
        chk_ack("R11 line drop clears", 1, NONE);
        chk("R11 irq drops", 32'(irq_o), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule